// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects interrupt events for a small microcontroller core and decides when to signal the core and which vector address it should fetch from. Its state is one 8-bit control/status register that the CPU reads and writes. The register holds a flag and an enable for each of three fixed sources (timer overflow, external edge, port change), together with two global-enable bits. A separate level input carries a combined request from the peripheral flag registers, which live outside this block.

Two operating modes exist, chosen by a level input. In legacy mode, bit 7 acts as a single global enable, bit 6 gates the peripheral request, and every interrupt goes to the high vector. In priority mode, the same two bits become the high-level and low-level global enables. The timer and port-change sources each take their level from a priority-select input. The external source is always high level. The peripheral request has no effect in this mode.

The core pulses an entry strobe when it vectors. On that edge the block latches the vector address and clears the global enable for the level being taken. A return strobe from the core sets one of the global enables again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `irq_req` is low and `vec_addr` is 0x0008.
- R2: When `csr_wr_en` is high, the register takes `csr_wr_data` on the clock edge. `csr_rd_data` always shows the register. Bit layout from bit 7 down to bit 0: high/global enable, low/peripheral enable, timer enable, external enable, port-change enable, timer flag, external flag, port-change flag.
- R3: A pulse on `src_set[i]` sets flag bit i on the next edge. This includes the case where a CPU write in the same cycle clears that flag. Bit mapping: 2 = timer, 1 = external, 0 = port change.
- R4: In legacy mode (`prio_mode` = 0), `irq_req` = bit7 AND (some source has both its flag bit and its enable bit, three positions above the flag, set, OR (bit6 AND `perip_req`)).
- R5: In legacy mode, `perip_req` by itself raises `irq_req` only when bits 7 and 6 are both set.
- R6: In priority mode, `irq_req` is low whenever bit 7 is clear, and `perip_req` has no effect.
- R7: In priority mode, a source is high level when `src_lvl_hi[i]` is 1, and the external source (i = 1) is always high level. An active high-level source raises `irq_req` when bit 7 is set. An active low-level source needs bits 7 and 6 both set.
- R8: On a cycle with `vec_enter` high, `vec_addr` loads 0x0008 in legacy mode, and also in priority mode when any high-level source is active. Otherwise it loads 0x0018. It holds its value between entries.
- R9: On a cycle with `vec_enter` high, bit 7 is cleared when the high vector is taken. Otherwise bit 6 is cleared.
- R10: On a cycle with `vec_return` high and `vec_enter` low, priority mode sets bit 6 if bit 7 is already set, and sets bit 7 if it is not. Legacy mode sets bit 7. When both strobes are high, entry wins.
- R11: Updates in one cycle apply in this order: CPU write, then flag pulses, then the entry or return change to the global bits (acting on the written value). The vector choice uses the register as it stood before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr_en | input | 1 | CPU write strobe for the control/status register |
| csr_wr_data | input | 8 | CPU write data |
| csr_rd_data | output | 8 | Current register contents |
| src_set | input | 3 | Per-source flag-set pulses (2 timer, 1 external, 0 port change) |
| perip_req | input | 1 | Combined peripheral interrupt request |
| prio_mode | input | 1 | 1 = two-level priority mode, 0 = legacy mode |
| src_lvl_hi | input | 3 | Per-source level select, 1 = high; bit 1 ignored |
| vec_enter | input | 1 | Core is vectoring to the interrupt this cycle |
| vec_return | input | 1 | Core is returning from interrupt this cycle |
| irq_req | output | 1 | Interrupt request to the core (combinational) |
| vec_addr | output | 16 | Registered vector address |

## Verification
Some properties are checked by assertions on every cycle. A flag pulse always leaves its flag set. A request never appears with bit 7 clear. An active external source always selects the high level. The vector holds between entries. In legacy mode, entry always clears bit 7 and return always sets it. Other behaviour can only be shown by the bench's scenarios, because it depends on how stimuli combine. This covers the low-level gating by bit 6, the per-source level selects, the choice of which global bit entry or return touches in priority mode, the write-versus-pulse race, and entry winning over return. A behavioural model compares all outputs on every cycle through directed and random sequences.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned NSRC  = 3;
  localparam int unsigned CSR_W = 2 + 2 * NSRC;

  // register view: [7] high/global enable, [6] low/peripheral enable,
  // [5:3] source enables, [2:0] source flags
  typedef struct packed {
    logic            ghi;
    logic            glo;
    logic [NSRC-1:0] en;
    logic [NSRC-1:0] flg;
  } csr_t;

  localparam int unsigned SRC_TMR = 2;
  localparam int unsigned SRC_EXT = 1;
  localparam int unsigned SRC_CHG = 0;

  // sources whose level is fixed to high regardless of the select input
  localparam logic [NSRC-1:0] FIXED_HI_MASK = 3'b010;
endpackage

// File: rtl/irq_csr.sv
module irq_csr
  import prio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  csr_t            wr_data,
  input  logic [NSRC-1:0] set_pulse,
  input  logic            enter,
  input  logic            reti,
  input  logic            prio_mode,
  input  logic            take_hi,
  output csr_t            csr_q
);
  csr_t            base;
  logic [NSRC-1:0] flg_nxt;
  logic            ghi_nxt;
  logic            glo_nxt;

  assign base = wr_en ? wr_data : csr_q;

  // flag set pulses override whatever the write put there
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    assign flg_nxt[i] = set_pulse[i] | base.flg[i];
  end

  always_comb begin
    ghi_nxt = base.ghi;
    glo_nxt = base.glo;
    if (enter) begin
      if (take_hi) ghi_nxt = 1'b0;
      else         glo_nxt = 1'b0;
    end else if (reti) begin
      if (prio_mode && base.ghi) glo_nxt = 1'b1;
      else                       ghi_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q <= '0;
    end else begin
      csr_q.ghi <= ghi_nxt;
      csr_q.glo <= glo_nxt;
      csr_q.en  <= base.en;
      csr_q.flg <= flg_nxt;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse[i] |=> csr_q.flg[i]);
  end

  a_r9_legacy_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (enter && !prio_mode) |=> !csr_q.ghi);

  a_r10_legacy_return: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !enter && !prio_mode) |=> csr_q.ghi);
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve
  import prio_irq_pkg::*;
(
  input  csr_t            csr,
  input  logic            prio_mode,
  input  logic [NSRC-1:0] src_lvl_hi,
  input  logic            perip_req,
  output logic            irq,
  output logic            take_hi
);
  logic [NSRC-1:0] act;
  logic [NSRC-1:0] hi_mask;
  logic            hi_any;
  logic            lo_any;
  logic            legacy_req;
  logic            prio_req;

  assign act = csr.en & csr.flg;

  for (genvar i = 0; i < NSRC; i++) begin : g_lvl
    if (FIXED_HI_MASK[i]) begin : g_fixed
      assign hi_mask[i] = 1'b1;
    end else begin : g_sel
      assign hi_mask[i] = src_lvl_hi[i];
    end
  end

  assign hi_any     = |(act & hi_mask);
  assign lo_any     = |(act & ~hi_mask);
  assign legacy_req = csr.ghi && ((|act) || (csr.glo && perip_req));
  assign prio_req   = csr.ghi && (hi_any || (csr.glo && lo_any));
  assign irq        = prio_mode ? prio_req : legacy_req;
  assign take_hi    = !prio_mode || hi_any;

  always_comb begin
    if (!csr.ghi) a_r6_gate: assert (!irq);
    if (prio_mode && csr.en[SRC_EXT] && csr.flg[SRC_EXT]) a_r7_ext_hi: assert (take_hi);
  end
endmodule

// File: rtl/irq_vector.sv
module irq_vector #(
  parameter int unsigned    VEC_W  = 16,
  parameter logic [VEC_W-1:0] VEC_HI = 16'h0008,
  parameter logic [VEC_W-1:0] VEC_LO = 16'h0018
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter,
  input  logic             take_hi,
  output logic [VEC_W-1:0] vec_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vec_q <= VEC_HI;
    else if (enter) vec_q <= take_hi ? VEC_HI : VEC_LO;
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !enter |=> $stable(vec_q));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned      VEC_W  = 16,
  parameter logic [VEC_W-1:0] VEC_HI = 16'h0008,
  parameter logic [VEC_W-1:0] VEC_LO = 16'h0018
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr_en,
  input  logic [CSR_W-1:0] csr_wr_data,
  output logic [CSR_W-1:0] csr_rd_data,
  input  logic [NSRC-1:0]  src_set,
  input  logic             perip_req,
  input  logic             prio_mode,
  input  logic [NSRC-1:0]  src_lvl_hi,
  input  logic             vec_enter,
  input  logic             vec_return,
  output logic             irq_req,
  output logic [VEC_W-1:0] vec_addr
);
  csr_t csr_q;
  logic take_hi;

  irq_csr u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (csr_wr_en),
    .wr_data   (csr_t'(csr_wr_data)),
    .set_pulse (src_set),
    .enter     (vec_enter),
    .reti      (vec_return),
    .prio_mode (prio_mode),
    .take_hi   (take_hi),
    .csr_q     (csr_q)
  );

  irq_resolve u_resolve (
    .csr        (csr_q),
    .prio_mode  (prio_mode),
    .src_lvl_hi (src_lvl_hi),
    .perip_req  (perip_req),
    .irq        (irq_req),
    .take_hi    (take_hi)
  );

  irq_vector #(.VEC_W(VEC_W), .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)) u_vector (
    .clk     (clk),
    .rst_n   (rst_n),
    .enter   (vec_enter),
    .take_hi (take_hi),
    .vec_q   (vec_addr)
  );

  assign csr_rd_data = csr_q;
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [2:0]  set_p = '0;
  logic        preq = 1'b0;
  logic        pmode = 1'b0;
  logic [2:0]  lvl = '0;
  logic        ent = 1'b0;
  logic        ret = 1'b0;
  logic        irq;
  logic [15:0] vec;

  int    vectors = 0;
  int    errors  = 0;
  string cur_req = "R1";
  bit    done    = 0;

  logic [7:0]  m_reg = 8'h00;
  logic [15:0] m_vec = 16'h0008;

  always #10 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(wr_en), .csr_wr_data(wr_data),
    .csr_rd_data(rd_data), .src_set(set_p), .perip_req(preq), .prio_mode(pmode),
    .src_lvl_hi(lvl), .vec_enter(ent), .vec_return(ret), .irq_req(irq), .vec_addr(vec)
  );

  function automatic bit src_active(input logic [7:0] r, input int s);
    return r[s] && r[s+3];
  endfunction

  function automatic bit src_high(input int s);
    if (s == 1) return 1'b1;
    return lvl[s];
  endfunction

  function automatic bit any_high(input logic [7:0] r);
    bit h = 0;
    for (int s = 0; s < 3; s++) if (src_active(r, s) && src_high(s)) h = 1;
    return h;
  endfunction

  function automatic bit model_irq(input logic [7:0] r);
    bit any = 0, lo = 0;
    for (int s = 0; s < 3; s++) begin
      if (src_active(r, s)) begin
        any = 1;
        if (!src_high(s)) lo = 1;
      end
    end
    if (!r[7]) return 1'b0;
    if (!pmode) return any || (r[6] && preq);
    return any_high(r) || (r[6] && lo);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 8'h00;
      m_vec = 16'h0008;
    end else begin
      logic [7:0] b;
      bit hi;
      hi = !pmode || any_high(m_reg);
      b = wr_en ? wr_data : m_reg;
      b[2:0] = b[2:0] | set_p;
      if (ent) begin
        if (hi) b[7] = 1'b0; else b[6] = 1'b0;
        m_vec = hi ? 16'h0008 : 16'h0018;
      end else if (ret) begin
        if (pmode && b[7]) b[6] = 1'b1; else b[7] = 1'b1;
      end
      m_reg = b;
    end
  end

  task automatic compare();
    bit ei;
    ei = model_irq(m_reg);
    vectors++;
    if (rd_data !== m_reg || irq !== ei || vec !== m_vec) begin
      errors++;
      $display("FAIL %s: rd=%02h irq=%0b vec=%04h expected rd=%02h irq=%0b vec=%04h",
               cur_req, rd_data, irq, vec, m_reg, ei, m_vec);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
    compare();
  endtask

  task automatic op(input bit w, input logic [7:0] d, input logic [2:0] sp,
                    input bit e, input bit r);
    wr_en = w; wr_data = d; set_p = sp; ent = e; ret = r;
    tick();
    wr_en = 0; set_p = '0; ent = 0; ret = 0;
    tick();
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R2 plain writes and readback
    cur_req = "R2";
    op(1, 8'hA5, 3'b000, 0, 0);
    op(1, 8'h00, 3'b000, 0, 0);
    // R3 flag pulses, including pulse racing a clearing write
    cur_req = "R3";
    op(0, 8'h00, 3'b100, 0, 0);
    op(1, 8'h00, 3'b011, 0, 0);
    // R4 legacy fixed sources
    cur_req = "R4";
    op(1, 8'hA4, 3'b000, 0, 0);
    op(1, 8'h24, 3'b000, 0, 0);
    op(1, 8'h89, 3'b000, 0, 0);
    op(1, 8'h82, 3'b000, 0, 0);
    // R5 peripheral request gating
    cur_req = "R5";
    preq = 1;
    op(1, 8'h80, 3'b000, 0, 0);
    op(1, 8'h40, 3'b000, 0, 0);
    op(1, 8'hC0, 3'b000, 0, 0);
    preq = 0; tick();
    // R6 priority mode gating
    cur_req = "R6";
    pmode = 1; preq = 1;
    op(1, 8'h52, 3'b000, 0, 0);
    op(1, 8'hC0, 3'b000, 0, 0);
    preq = 0;
    // R7 per-source levels
    cur_req = "R7";
    lvl = 3'b000;
    op(1, 8'hA4, 3'b000, 0, 0);
    op(1, 8'hE4, 3'b000, 0, 0);
    lvl = 3'b100; tick();
    op(1, 8'hA4, 3'b000, 0, 0);
    lvl = 3'b001;
    op(1, 8'h89, 3'b000, 0, 0);
    lvl = 3'b000; tick();
    // R8 / R9 vectoring entry
    cur_req = "R8";
    op(1, 8'hD2, 3'b000, 1, 0);
    cur_req = "R9";
    op(1, 8'hE4, 3'b000, 1, 0);
    op(1, 8'hC0, 3'b000, 1, 0);
    pmode = 0;
    op(1, 8'hC0, 3'b000, 1, 0);
    pmode = 1;
    // R10 return from interrupt
    cur_req = "R10";
    op(1, 8'h00, 3'b000, 0, 1);
    op(0, 8'h00, 3'b000, 0, 1);
    op(1, 8'hE4, 3'b000, 1, 1);
    pmode = 0;
    op(1, 8'h40, 3'b000, 0, 1);
    // R11 ordering: write with entry and return in same cycle
    cur_req = "R11";
    pmode = 1;
    op(1, 8'h80, 3'b010, 0, 1);
    op(1, 8'h12, 3'b000, 0, 0);
    op(1, 8'hC0, 3'b100, 1, 0);
    // mixed random traffic across all rules
    cur_req = "R4/R7/R9/R10";
    for (int k = 0; k < 600; k++) begin
      wr_en = ($urandom % 4) == 0; wr_data = 8'($urandom);
      set_p = 3'($urandom) & 3'($urandom);
      ent = ($urandom % 6) == 0; ret = ($urandom % 6) == 0;
      preq = 1'($urandom); lvl = 3'($urandom);
      if ((k % 50) == 0) pmode = ~pmode;
      tick();
    end
    wr_en = 0; set_p = '0; ent = 0; ret = 0;
    tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule